// File: doc/BRIEF.md
# Two-Wire Byte Register Slave

This block sits on a two-wire serial bus as a slave with a fixed device address. It gives a host read and write access to a small bank of byte-wide control registers. The clock and data lines are brought into the system clock domain through a two-stage synchroniser. The block pulls the data line low through a single open-drain enable, and it presents every register in parallel to the logic around it.

Only two transactions are understood. In a byte write, the address is sent with the write flag, then a command byte that picks the register, then the value to store. In a byte read, the address and command are sent, then a repeated START, then the address with the read flag, and the slave returns one byte. Each register has a mask of implemented bits. Bits outside the mask are reserved: they reset to zero and always read back as zero.

Top module: `smbus_regbank_slave`

## Requirements
- R1: The slave ACKs an address byte only when its upper seven bits equal 0x2C, that is byte 0x58 for write and 0x59 for read, with bit 0 as the read flag. Any other address gets no ACK, and the rest of that transaction until the next START or STOP changes nothing.
- R2: A byte write is a START, the write address, a command byte, a data byte and a STOP, and the slave ACKs all three bytes. The data is stored in the register whose index equals the command, and it appears on `regFile[8*i+7:8*i]` for index i.
- R3: A byte read is a START, the write address, a command byte, a repeated START, the read address and one returned byte. The slave returns the current content of the register picked by the most recent command byte, MSB first, and the bit is valid while SCL is high.
- R4: Reserved bits are masked. They are bits 7..4 of register 1 and bits 7..3 of register 3. They are stored as 0 whatever is written and read back as 0.
- R5: A command of 4 or more (outside the bank) is still ACKed. A write to it changes no register, and a read from it returns 0x00.
- R6: After synchronous reset, registers 0..3 hold 0x00, 0x05, 0x80 and 0x03, the bus logic is idle and the data line is released.
- R7: The slave pulls the data line low only during its own ACK bits and the zero bits of a returned byte. It releases the line after the master's ACK/NACK slot of a read, and the line changes only after SCL falls or at START/STOP.
- R8: START (SDA falls while SCL is high) restarts address reception from any state. STOP (SDA rises while SCL is high) makes the slave idle with the line released. A transaction cut off by either event writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Serial clock line as seen on the pin |
| sdaIn | input | 1 | Serial data line as seen on the pin |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| regFile | output | NUM_REGS*8 | All registers, register i in bits 8*i+7..8*i |

## Verification
Every bus edge reaches the control logic three system clocks after the pin changes: two synchroniser stages, then one edge-detect register. A change on `sdaDriveLow` follows one clock later, so it appears about four clocks after the SCL fall that causes it. A register write appears on `regFile` about four clocks after the rising SCL edge of the last data bit. The bench moves the bus lines once every eight clocks, samples SDA in the middle of the SCL-high phase, and reads the register outputs only after the STOP that follows. All sampling happens on the falling system clock edge, well after each result is due.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_DATA, ST_DATA_ACK, ST_TX, ST_MACK, ST_WAIT
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } strobe_t;

  // synchronised bus events
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sda;
  } busEvt_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync import smb_pkg::*; #(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sclIn,
  input  logic    sdaIn,
  output busEvt_t evt
);
  logic [STAGES-1:0] sclSr, sdaSr;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclSr   <= '1;
      sdaSr   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSr   <= {sclSr[STAGES-2:0], sclIn};
      sdaSr   <= {sdaSr[STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSr[STAGES-1];
  assign sdaS = sdaSr[STAGES-1];

  always_comb begin
    evt.sclRise = sclS & ~sclPrev;
    evt.sclFall = ~sclS & sclPrev;
    evt.start   = sclS & sclPrev & sdaPrev & ~sdaS;
    evt.stop    = sclS & sclPrev & ~sdaPrev & sdaS;
    evt.sda     = sdaS;
  end
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl import smb_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic      clk,
  input  logic      rst,
  input  busEvt_t   evt,
  input  logic      readMsb,
  input  logic      txNext,
  output strobe_t   stb,
  output logic [7:0] rxByte,
  output logic      sdaDriveLow,
  output busState_t state
);
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  logic       ackOn;
  logic       rdFlag;
  logic       byteDone;

  assign rxByte   = {rxShift, evt.sda};
  assign byteDone = evt.sclRise && (bitCnt == 3'd7);

  always_comb begin
    stb.loadCmd  = (state == ST_CMD)  && byteDone;
    stb.writeReg = (state == ST_DATA) && byteDone;
    stb.loadTx   = (state == ST_ADDR_ACK) && rdFlag && ackOn && evt.sclFall;
    stb.shiftTx  = (state == ST_TX) && evt.sclFall && (bitCnt != 3'd7);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      rxShift     <= '0;
      ackOn       <= 1'b0;
      rdFlag      <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (evt.start) begin
      state       <= ST_ADDR;
      bitCnt      <= '0;
      ackOn       <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (evt.stop) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      ackOn       <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_CMD, ST_DATA: begin
          if (evt.sclRise) begin
            rxShift <= rxByte[6:0];
            bitCnt  <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (state == ST_ADDR) begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  rdFlag <= rxByte[0];
                  state  <= ST_ADDR_ACK;
                end else begin
                  state  <= ST_WAIT;
                end
              end else if (state == ST_CMD) begin
                state <= ST_CMD_ACK;
              end else begin
                state <= ST_DATA_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_CMD_ACK, ST_DATA_ACK: begin
          if (evt.sclFall) begin
            if (!ackOn) begin
              ackOn       <= 1'b1;
              sdaDriveLow <= 1'b1;
            end else begin
              ackOn  <= 1'b0;
              bitCnt <= '0;
              if (state == ST_ADDR_ACK && rdFlag) begin
                state       <= ST_TX;
                sdaDriveLow <= ~readMsb;
              end else begin
                sdaDriveLow <= 1'b0;
                if (state == ST_ADDR_ACK)     state <= ST_CMD;
                else if (state == ST_CMD_ACK) state <= ST_DATA;
                else                          state <= ST_WAIT;
              end
            end
          end
        end
        ST_TX: begin
          if (evt.sclFall) begin
            if (bitCnt != 3'd7) begin
              bitCnt      <= bitCnt + 3'd1;
              sdaDriveLow <= ~txNext;
            end else begin
              sdaDriveLow <= 1'b0;
              state       <= ST_MACK;
            end
          end
        end
        ST_MACK: begin
          if (evt.sclRise) state <= ST_WAIT;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_regs.sv
module smb_regs import smb_pkg::*; #(
  parameter int                    NUM_REGS    = 4,
  parameter logic [NUM_REGS*8-1:0] REG_MASK    = '1,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULT = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               stb,
  input  logic [7:0]            rxByte,
  output logic                  readMsb,
  output logic                  txNext,
  output logic [NUM_REGS*8-1:0] regFile
);
  logic [7:0] cmdReg;
  logic [7:0] readData;
  logic [6:0] txShiftR;

  always_ff @(posedge clk) begin
    if (rst) cmdReg <= '0;
    else if (stb.loadCmd) cmdReg <= rxByte;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] MASK = REG_MASK[8*i +: 8];
    localparam logic [7:0] DEF  = REG_DEFAULT[8*i +: 8] & MASK;
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= DEF;
      else if (stb.writeReg && cmdReg == 8'(i)) q <= rxByte & MASK;
    end
    assign regFile[8*i +: 8] = q;
  end

  always_comb begin
    readData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (cmdReg == 8'(i)) readData = regFile[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) txShiftR <= '0;
    else if (stb.loadTx) txShiftR <= readData[6:0];
    else if (stb.shiftTx) txShiftR <= {txShiftR[5:0], 1'b0};
  end

  assign readMsb = readData[7];
  assign txNext  = txShiftR[6];
endmodule

// File: rtl/smbus_regbank_slave.sv
module smbus_regbank_slave import smb_pkg::*; #(
  parameter int                    NUM_REGS    = 4,
  parameter logic [6:0]            DEV_ADDR    = 7'h2C,
  parameter logic [NUM_REGS*8-1:0] REG_MASK    = 32'h07FF_0FFF,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULT = 32'h0380_0500
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  output logic [NUM_REGS*8-1:0] regFile
);
  busEvt_t   evt;
  strobe_t   stb;
  busState_t busState;
  logic [7:0] rxByte;
  logic readMsb, txNext;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn), .evt(evt)
  );

  smb_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .evt(evt), .readMsb(readMsb), .txNext(txNext),
    .stb(stb), .rxByte(rxByte), .sdaDriveLow(sdaDriveLow), .state(busState)
  );

  smb_regs #(.NUM_REGS(NUM_REGS), .REG_MASK(REG_MASK), .REG_DEFAULT(REG_DEFAULT)) u_regs (
    .clk(clk), .rst(rst), .stb(stb), .rxByte(rxByte),
    .readMsb(readMsb), .txNext(txNext), .regFile(regFile)
  );
endmodule

// File: rtl/smb_slave_checker.sv
module smb_slave_checker import smb_pkg::*; #(
  parameter int                    NUM_REGS = 4,
  parameter logic [NUM_REGS*8-1:0] REG_MASK = '1
) (
  input logic                  clk,
  input logic                  rst,
  input busEvt_t               evt,
  input strobe_t               stb,
  input busState_t             busState,
  input logic                  sdaDriveLow,
  input logic [NUM_REGS*8-1:0] regFile
);
  // line only moves after an SCL fall or a START/STOP (R7)
  p_drive_moves_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !(evt.sclFall || evt.start || evt.stop) |=> $stable(sdaDriveLow));

  // no drive outside ACK and transmit states (R7)
  p_released_outside_slots_r7: assert property (@(posedge clk) disable iff (rst)
    (busState inside {ST_IDLE, ST_WAIT, ST_ADDR, ST_CMD, ST_DATA, ST_MACK}) |-> !sdaDriveLow);

  // STOP idles and releases (R8)
  p_stop_idles_r8: assert property (@(posedge clk) disable iff (rst)
    evt.stop |=> (busState == ST_IDLE && !sdaDriveLow));

  // START restarts address reception (R8)
  p_start_restarts_r8: assert property (@(posedge clk) disable iff (rst)
    evt.start |=> (busState == ST_ADDR));

  // registers change only on a write strobe (R2)
  p_hold_without_write_r2: assert property (@(posedge clk) disable iff (rst)
    !stb.writeReg |=> $stable(regFile));

  // reserved bits stay zero (R4)
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (regFile & ~REG_MASK) == '0);
endmodule

bind smbus_regbank_slave smb_slave_checker #(.NUM_REGS(NUM_REGS), .REG_MASK(REG_MASK)) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .stb(stb), .busState(busState),
  .sdaDriveLow(sdaDriveLow), .regFile(regFile)
);

// File: tb/sim_smbus_regbank_slave.sv
module sim_smbus_regbank_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaDriveLow;
  logic [31:0] regFile;
  wire  sdaLine = mSda & ~sdaDriveLow;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  smbus_regbank_slave u0 (
    .clk(clk), .rst(rst), .sclIn(scl), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .regFile(regFile)
  );

  // {isRead, cmd, data, expected}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'hA5, 8'hA5}, {1'b1, 8'h00, 8'h00, 8'hA5},
    {1'b0, 8'h01, 8'hFF, 8'h0F}, {1'b1, 8'h01, 8'h00, 8'h0F},
    {1'b0, 8'h02, 8'h3C, 8'h3C}, {1'b1, 8'h02, 8'h00, 8'h3C},
    {1'b0, 8'h03, 8'hFF, 8'h07}, {1'b1, 8'h03, 8'h00, 8'h07},
    {1'b0, 8'h09, 8'h77, 8'h00}, {1'b1, 8'h09, 8'h00, 8'h00},
    {1'b1, 8'hFF, 8'h00, 8'h00}, {1'b1, 8'h00, 8'h00, 8'hA5}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (8) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ();
    scl = 1'b1;  waitQ();
    mSda = 1'b0; waitQ();
    scl = 1'b0;  waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    scl = 1'b1;  waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ();
      scl = 1'b1;  waitQ(); waitQ();
      scl = 1'b0;  waitQ();
    end
    mSda = 1'b1; waitQ();
    scl = 1'b1;  waitQ();
    ack = ~sdaLine;
    waitQ();
    scl = 1'b0;  waitQ();
  endtask

  task automatic recvByte(output logic [7:0] d);
    mSda = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      waitQ();
      scl = 1'b1; waitQ();
      d = {d[6:0], sdaLine};
      waitQ();
      scl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ();   // master NACK
    scl = 1'b1;  waitQ(); waitQ();
    scl = 1'b0;  waitQ();
  endtask

  task automatic doWrite(logic [7:0] addr, logic [7:0] cmd, logic [7:0] data, output logic [2:0] acks);
    busStart();
    sendByte(addr, acks[2]);
    sendByte(cmd, acks[1]);
    sendByte(data, acks[0]);
    busStop();
  endtask

  task automatic doRead(logic [7:0] cmd, output logic [7:0] d, output logic [2:0] acks);
    busStart();
    sendByte(8'h58, acks[2]);
    sendByte(cmd, acks[1]);
    busStart();
    sendByte(8'h59, acks[0]);
    recvByte(d);
    busStop();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [2:0] acks;
    logic [7:0] d;
    logic ack;
    logic [31:0] snap;
    string tag;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R6 reset state
    chk("R6 regFile", regFile, 32'h0380_0500);
    chk("R6 drive", {31'd0, sdaDriveLow}, 32'd0);
    doRead(8'h01, d, acks);
    chk("R6 read default", {24'd0, d}, 32'h05);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] cmd, data, exp;
      cmd  = VEC[v][23:16];
      data = VEC[v][15:8];
      exp  = VEC[v][7:0];
      if (cmd >= 8'd4)     tag = "R5";
      else if (exp != data && !VEC[v][24]) tag = "R4";
      else if (VEC[v][24]) tag = "R3";
      else                 tag = "R2";
      snap = regFile;
      if (VEC[v][24]) begin
        doRead(cmd, d, acks);
        chk({tag, " read data"}, {24'd0, d}, {24'd0, exp});
        chk("R1 read acks", {29'd0, acks}, 32'd7);
        chk("R7 released after read", {31'd0, sdaDriveLow}, 32'd0);
      end else begin
        doWrite(8'h58, cmd, data, acks);
        chk("R1 write acks", {29'd0, acks}, 32'd7);
        if (cmd < 8'd4) chk({tag, " stored"}, {24'd0, regFile[cmd*8 +: 8]}, {24'd0, exp});
        else            chk("R5 ignored write", regFile, snap);
      end
    end

    // R1 wrong address: NACK and nothing written
    snap = regFile;
    busStart();
    sendByte(8'h5A, ack);
    chk("R1 wrong addr nack", {31'd0, ack}, 32'd0);
    sendByte(8'h00, ack);
    chk("R1 no ack after mismatch", {31'd0, ack}, 32'd0);
    sendByte(8'h11, ack);
    busStop();
    chk("R1 no write on mismatch", regFile, snap);

    // R8 repeated START aborts a write, then a new one lands
    busStart();
    sendByte(8'h58, ack);
    sendByte(8'h00, ack);
    busStart();
    sendByte(8'h58, ack);
    sendByte(8'h02, ack);
    sendByte(8'h11, ack);
    busStop();
    chk("R8 reg0 untouched", {24'd0, regFile[7:0]}, 32'hA5);
    chk("R8 reg2 written", {24'd0, regFile[23:16]}, 32'h11);

    // R8 STOP after command only: no write, line released, command kept
    snap = regFile;
    busStart();
    sendByte(8'h58, ack);
    sendByte(8'h03, ack);
    busStop();
    chk("R8 stop no write", regFile, snap);
    chk("R8 stop release", {31'd0, sdaDriveLow}, 32'd0);

    // R3 read of a value with zero bits, drives line
    doRead(8'h02, d, acks);
    chk("R3 read reg2", {24'd0, d}, 32'h11);

    // R6 reset mid-run restores defaults
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 reset restores", regFile, 32'h0380_0500);
    chk("R6 reset release", {31'd0, sdaDriveLow}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule